// File: doc/BRIEF.md
# Layer Readout Controller with Sparse Hit Encoding

This controller terminates a chain of front-end strip chips. When the front end asks for a readout, the controller acknowledges the request and takes in the serial strip bitstream. It keeps only the positions of the strips that fired, as 11-bit addresses, along with a count of those addresses. While that happens it measures how many clock cycles the prompt fast-OR trigger stays high. Each such width is queued in a small FIFO and attached to the next event that completes.

Finished events wait in one of two buffers, so a new event can be built while an older one waits for the output. The output is a serial data line shared by several layers. A layer may drive that line only while it holds a token passed from layer to layer. Each time the token arrives, the controller sends its oldest stored event as one frame, then passes the token on. If it has nothing stored, it passes the token on at once.

Top module: `layer_readout_ctrl`

## Requirements
- R1: After reset, `trig_ack`, `data_en`, `data_out` and `token_out` are all 0.
- R2: Bits of an event stream are numbered from 0, the first bit received with `ser_valid` high. Each bit equal to 1 is stored as its 11-bit position number, and stored addresses are sent in the order they arrived. Position 1599 is sent as 11'h63F.
- R3: The hit count sent with an event equals the number of set bits in its stream, up to `MAX_HITS` (default 16). Set bits beyond that limit are dropped and not counted.
- R4: A frame is sent MSB first in this order: one start bit of value 1, then the 11-bit hit count, then each 11-bit address, then the `TOT_W`-bit (default 8) trigger width. `data_en` is high for exactly the 1+11+11·count+`TOT_W` frame cycles.
- R5: The trigger width is the number of rising clock edges at which `trig_in` was sampled high, saturating at 2^`TOT_W`−1. A width is queued when `trig_in` falls. Completed events take queued widths in order. An event that completes while the queue is empty carries 0.
- R6: There are two event buffers. A second event is acknowledged and built while the first is still waiting to be sent.
- R7: `trig_ack` is a one-cycle pulse. While both buffers hold unsent events, it stays low even if `trig_req` is held. It is given again once a frame has been sent.
- R8: `data_en` rises only after `token_in` has been received. Each token sends at most one event, and events leave oldest first.
- R9: `token_out` pulses for one cycle in the cycle right after the last frame bit. If no event is stored, it pulses on the second rising edge after `token_in` is sampled, and `data_en` stays low.
- R10: An event with no set bits is sent with a count of 0, no address fields, and then its trigger width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Fast-OR trigger level from the front end |
| trig_req | input | 1 | Request to read out an event |
| trig_ack | output | 1 | One-cycle grant: a buffer is assigned and the stream may start |
| ser_valid | input | 1 | Stream bit valid |
| ser_bit | input | 1 | Strip hit bit |
| ser_last | input | 1 | Marks the last bit of the event stream |
| token_in | input | 1 | Token pulse from the previous layer |
| token_out | output | 1 | Token pulse to the next layer |
| data_out | output | 1 | Serial frame data onto the shared line |
| data_en | output | 1 | Drive enable for the shared line |

## Verification
The bench targets these corner cases, and what a faulty design would show:
- A hit on bit 0 and a hit on bit 1599: an off-by-one position counter shifts every address sent.
- A trigger held for 300 cycles: a wrapping width counter sends 44 instead of 255.
- A stream with 20 hits: without the limit, the count field overruns storage.
- An event with no hits: a design that skips the zero case emits a bogus address word.
- Three requests while nothing is sent: a controller that overwrites an unsent buffer would acknowledge the third request early, or lose the oldest frame.
- A token arriving when nothing is stored: a design that does not forward it would stall every layer after this one.

// File: rtl/layer_readout_ctrl.sv
module layer_readout_ctrl #(
  parameter int N_STRIPS  = 1600,
  parameter int MAX_HITS  = 16,
  parameter int TOT_W     = 8,
  parameter int TOT_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic trig_req,
  output logic trig_ack,
  input  logic ser_valid,
  input  logic ser_bit,
  input  logic ser_last,
  input  logic token_in,
  output logic token_out,
  output logic data_out,
  output logic data_en
);
  localparam int ADDR_W = $clog2(N_STRIPS);
  localparam int HCW    = $clog2(MAX_HITS + 1);
  localparam int WW     = $clog2(MAX_HITS);
  localparam int BW     = $clog2((ADDR_W > TOT_W) ? ADDR_W : TOT_W);
  localparam int FPW    = $clog2(TOT_DEPTH);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_CNT, TX_ADR, TX_TOT} tx_t;

  // trigger width measurement and queue
  logic [TOT_W-1:0] tot_run;
  logic [TOT_W-1:0] tq [TOT_DEPTH];
  logic [FPW:0]     tq_wp, tq_rp;
  logic [FPW:0]     tq_cnt;
  logic             tq_push, tq_pop;

  // event assembly
  logic              building, wr_sel;
  logic [ADDR_W-1:0] bit_idx;
  logic [HCW-1:0]    bld_cnt;
  logic              hit_take, ev_done;
  logic [ADDR_W-1:0] mem [2][MAX_HITS];
  logic [ADDR_W-1:0] ev_cnt [2];
  logic [TOT_W-1:0]  ev_tot [2];
  logic [1:0]        full_q, set_v, clr_v;

  // transmit
  tx_t               phase;
  logic              tok_held, rd_sel;
  logic [BW-1:0]     b;
  logic [WW-1:0]     word;
  logic [ADDR_W-1:0] cur_word, shifted;

  assign tq_cnt   = tq_wp - tq_rp;
  assign tq_push  = !trig_in && (tot_run != '0) && (tq_cnt != (FPW+1)'(TOT_DEPTH));
  assign ev_done  = building && ser_valid && ser_last;
  assign tq_pop   = ev_done && (tq_cnt != '0);
  assign hit_take = building && ser_valid && ser_bit && (bld_cnt < HCW'(MAX_HITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_run <= '0;
      tq_wp   <= '0;
      tq_rp   <= '0;
    end else begin
      if (trig_in) tot_run <= (tot_run == TOT_MAX) ? tot_run : tot_run + 1'b1;
      else         tot_run <= '0;
      if (tq_push) begin
        tq[tq_wp[FPW-1:0]] <= tot_run;
        tq_wp <= tq_wp + 1'b1;
      end
      if (tq_pop) tq_rp <= tq_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      building <= 1'b0;
      trig_ack <= 1'b0;
      wr_sel   <= 1'b0;
      bit_idx  <= '0;
      bld_cnt  <= '0;
    end else begin
      trig_ack <= 1'b0;
      if (!building) begin
        if (trig_req && !full_q[wr_sel]) begin
          trig_ack <= 1'b1;
          building <= 1'b1;
          bit_idx  <= '0;
          bld_cnt  <= '0;
        end
      end else if (ser_valid) begin
        bit_idx <= bit_idx + 1'b1;
        if (hit_take) bld_cnt <= bld_cnt + 1'b1;
        if (ser_last) begin
          building <= 1'b0;
          wr_sel   <= ~wr_sel;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit_take) mem[wr_sel][bld_cnt[WW-1:0]] <= bit_idx;
    if (ev_done) begin
      ev_cnt[wr_sel] <= ADDR_W'(bld_cnt) + ADDR_W'(hit_take);
      ev_tot[wr_sel] <= (tq_cnt != '0) ? tq[tq_rp[FPW-1:0]] : '0;
    end
  end

  assign set_v = ev_done ? (2'b01 << wr_sel) : 2'b00;
  assign clr_v = (phase == TX_TOT && b == '0) ? (2'b01 << rd_sel) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= 2'b00;
    else        full_q <= (full_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= TX_IDLE;
      tok_held  <= 1'b0;
      rd_sel    <= 1'b0;
      b         <= '0;
      word      <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= 1'b0;
      if (token_in) tok_held <= 1'b1;
      case (phase)
        TX_IDLE: if (tok_held) begin
          if (full_q[rd_sel]) phase <= TX_START;
          else begin
            token_out <= 1'b1;
            tok_held  <= 1'b0;
          end
        end
        TX_START: begin
          phase <= TX_CNT;
          b     <= BW'(ADDR_W - 1);
        end
        TX_CNT: if (b == '0) begin
          if (ev_cnt[rd_sel] == '0) begin
            phase <= TX_TOT;
            b     <= BW'(TOT_W - 1);
          end else begin
            phase <= TX_ADR;
            word  <= '0;
            b     <= BW'(ADDR_W - 1);
          end
        end else b <= b - 1'b1;
        TX_ADR: if (b == '0) begin
          if (ADDR_W'(word) == ev_cnt[rd_sel] - ADDR_W'(1)) begin
            phase <= TX_TOT;
            b     <= BW'(TOT_W - 1);
          end else begin
            word <= word + 1'b1;
            b    <= BW'(ADDR_W - 1);
          end
        end else b <= b - 1'b1;
        TX_TOT: if (b == '0) begin
          phase     <= TX_IDLE;
          rd_sel    <= ~rd_sel;
          token_out <= 1'b1;
          tok_held  <= 1'b0;
        end else b <= b - 1'b1;
        default: phase <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      TX_CNT:  cur_word = ev_cnt[rd_sel];
      TX_ADR:  cur_word = mem[rd_sel][word];
      TX_TOT:  cur_word = ADDR_W'(ev_tot[rd_sel]);
      default: cur_word = '0;
    endcase
  end

  assign shifted  = cur_word >> b;
  assign data_en  = (phase != TX_IDLE);
  assign data_out = (phase == TX_START) | (data_en & shifted[0]);

  AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_q) |=> !trig_ack); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ack |=> !trig_ack); // R7
  AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out); // R9
  AST_DRIVE_WITH_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> tok_held); // R8
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en) |-> data_out); // R4
  AST_TOT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && tot_run == TOT_MAX) |=> tot_run == TOT_MAX); // R5
  AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bld_cnt <= HCW'(MAX_HITS)); // R3
endmodule

// File: tb/layer_readout_ctrl_tb.sv
module layer_readout_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 0, trig_req = 0, ser_valid = 0, ser_bit = 0, ser_last = 0, token_in = 0;
  logic trig_ack, token_out, data_out, data_en;

  always #2 clk = ~clk;

  layer_readout_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_req(trig_req), .trig_ack(trig_ack),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .ser_last(ser_last), .token_in(token_in),
    .token_out(token_out), .data_out(data_out), .data_en(data_en));

  int n_chk = 0, n_bad = 0;
  logic [1599:0] bm;
  int exp_cnt [4];
  int exp_adr [4][16];
  int exp_tot [4];
  int ew = 0, er = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse_trig(input int len);
    trig_in = 1;
    repeat (len) @(negedge clk);
    trig_in = 0;
    @(negedge clk);
  endtask

  task automatic get_ack();
    bit seen = 0;
    trig_req = 1;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (trig_ack) seen = 1;
    end
    trig_req = 0;
    chk(seen, "R6 ack granted", seen, 1);
    @(negedge clk);
    chk(trig_ack == 0, "R7 ack one cycle", trig_ack, 0);
  endtask

  task automatic stream_ev(input int nbits, input int tot);
    int c = 0;
    for (int i = 0; i < nbits; i++) begin
      if (bm[i] && c < 16) begin exp_adr[ew][c] = i; c++; end
    end
    exp_cnt[ew] = c;
    exp_tot[ew] = tot;
    ew = (ew + 1) % 4;
    for (int i = 0; i < nbits; i++) begin
      ser_valid = 1; ser_bit = bm[i]; ser_last = (i == nbits - 1);
      @(negedge clk);
    end
    ser_valid = 0; ser_bit = 0; ser_last = 0;
  endtask

  task automatic read_frame(input string tag);
    logic fr [256];
    int nb = 0, w = 0, pos, cnt, tv;
    token_in = 1;
    @(negedge clk);
    token_in = 0;
    for (int i = 0; i < 10 && !data_en; i++) @(negedge clk);
    chk(data_en == 1, {"R8 frame starts ", tag}, data_en, 1);
    while (data_en && nb < 256) begin
      fr[nb] = data_out; nb++;
      @(negedge clk);
    end
    chk(token_out == 1, {"R9 token after frame ", tag}, token_out, 1);
    chk(fr[0] == 1, {"R4 start bit ", tag}, fr[0], 1);
    cnt = 0;
    for (int k = 1; k <= 11; k++) cnt = (cnt << 1) | int'(fr[k]);
    chk(cnt == exp_cnt[er], {"R3 hit count ", tag}, cnt, exp_cnt[er]);
    chk(nb == 20 + 11 * exp_cnt[er], {"R4 frame length ", tag}, nb, 20 + 11 * exp_cnt[er]);
    pos = 12;
    for (int a = 0; a < exp_cnt[er] && a < cnt; a++) begin
      w = 0;
      for (int k = 0; k < 11; k++) w = (w << 1) | int'(fr[pos + k]);
      pos += 11;
      chk(w == exp_adr[er][a], {"R2 address ", tag}, w, exp_adr[er][a]);
    end
    tv = 0;
    for (int k = 0; k < 8; k++) tv = (tv << 1) | int'(fr[pos + k]);
    chk(tv == exp_tot[er], {"R5 trigger width ", tag}, tv, exp_tot[er]);
    er = (er + 1) % 4;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(trig_ack == 0, "R1 ack reset", trig_ack, 0);
    chk(data_en == 0, "R1 data_en reset", data_en, 0);
    chk(data_out == 0, "R1 data_out reset", data_out, 0);
    chk(token_out == 0, "R1 token_out reset", token_out, 0);
  endtask

  task automatic t_basic();
    pulse_trig(5);
    get_ack();
    bm = '0; bm[0] = 1; bm[7] = 1; bm[39] = 1;
    stream_ev(40, 5);
    read_frame("basic");
  endtask

  task automatic t_zero_sat();
    pulse_trig(300);
    get_ack();
    bm = '0;
    stream_ev(64, 255);
    read_frame("R10 empty event, saturated width");
  endtask

  task automatic t_overflow();
    pulse_trig(3);
    get_ack();
    bm = '0;
    for (int k = 0; k < 20; k++) bm[k * 80 + 1] = 1;
    stream_ev(1600, 3);
    pulse_trig(2);
    get_ack();
    bm = '0; bm[1599] = 1;
    stream_ev(1600, 2);
    read_frame("R3 limit");
    read_frame("R2 last strip");
  endtask

  task automatic t_double();
    bit seen = 0;
    pulse_trig(4); get_ack();
    bm = '0; bm[3] = 1; stream_ev(10, 4);
    pulse_trig(6); get_ack();
    bm = '0; bm[1] = 1; bm[2] = 1; stream_ev(10, 6);
    pulse_trig(7);
    trig_req = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (trig_ack) seen = 1;
    end
    chk(!seen, "R7 held off when both full", seen, 0);
    read_frame("R8 oldest first");
    seen = 0;
    for (int i = 0; i < 6 && !seen; i++) begin
      if (trig_ack) seen = 1; else @(negedge clk);
    end
    trig_req = 0;
    chk(seen, "R7 ack after buffer freed", seen, 1);
    @(negedge clk);
    bm = '0; bm[9] = 1; stream_ev(10, 7);
    read_frame("R6 second buffer");
    read_frame("third event");
  endtask

  task automatic t_empty_token();
    bit drove = 0;
    token_in = 1;
    @(negedge clk);
    token_in = 0;
    if (data_en) drove = 1;
    chk(token_out == 0, "R9 no early token", token_out, 0);
    @(negedge clk);
    if (data_en) drove = 1;
    chk(token_out == 1, "R9 token passed when empty", token_out, 1);
    @(negedge clk);
    chk(token_out == 0, "R9 token one cycle", token_out, 0);
    chk(!drove && !data_en, "R8 no drive when empty", drove, 0);
  endtask

  task automatic t_no_width();
    get_ack();
    bm = '0; bm[5] = 1;
    stream_ev(8, 0);
    read_frame("R5 empty width queue");
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_sat();
    t_overflow();
    t_double();
    t_empty_token();
    t_no_width();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule